// File: doc/BRIEF.md
# Big-Number Operation Control Register

This block is the host-facing control and status front end of a multi-word arithmetic coprocessor. A host uses a small synchronous register bus to program the operand vector pointers, the operand lengths and a shift amount. It then writes a function word that picks one basic operation, or one complex sequenced operation, and sets the run bit. The block checks that the operation selection is legal. It latches the operation code and a snapshot of the pointer and length registers, then gives the arithmetic datapath a one-cycle start pulse. The datapath reports completion with a one-cycle done pulse that carries the compare flags and two most-significant-word results.

Pointer and length registers have a host-side copy and a datapath-side copy, so the host can stage the next operation while the current one runs. A stall-result control lets the host hold back publication of a finished basic operation, and the clearing of run, until it has read the previous results. The interrupt output is the inverse of run. Out of reset the block reports run = 1 until the sequencer side signals, with a boot-clear pulse, that it is ready.

Start and done are plain pulses with no back-pressure. The datapath must accept a start in the cycle it is asserted. The block accepts a done pulse in any cycle while an operation is in flight and ignores it otherwise. Register reads have no wait states.

Top module: `bignum_ctl`

## Requirements
- R1: Out of reset the run bit (function word bit 15) reads 1, `irq` is 0 and the three result registers read 0. While in this boot state a start request is ignored. One cycle after a `boot_clr` pulse is sampled, run reads 0 and `irq` is 1.
- R2: In idle, a host write to the function word (address 0) with bit 15 set and a legal selection raises `dp_start` for exactly the following cycle. During that cycle `dp_basic_op` equals written bits 11:0 and `dp_seq_op` equals written bits 14:12, and run reads 1.
- R3: Function word layout: bit 0 multiply, 1 add/subtract, 3 most-significant-one modifier, 4 add, 5 subtract, 6 right shift, 7 left shift, 8 divide, 9 modulo, 10 compare, 11 copy, 14:12 complex select, 15 run, 24 stall-result. A selection is legal when the complex select is zero and exactly one of the operation bits 0, 1 and 4 to 11 is set, or when the select is nonzero and none of them is set. An illegal start raises no `dp_start`, leaves run at 0 and sets status (address 2) bit 0. The next legal start clears that bit.
- R4: A `dp_done` pulse during a basic operation with stall-result 0 makes compare (address 12, 3 bits), MSW (address 13, 16 bits) and DIVMSW (address 14, 16 bits) read the datapath values, with run at 0, in the next cycle.
- R5: `irq` always equals the inverse of the run bit.
- R6: While a basic operation is in flight (running or held), writes to function bits 11:0 and to the shift register (address 1) are ignored. A write with run set does not start a second operation, and stall-result stays writable.
- R7: With stall-result 1 at completion of a basic operation, the results stay unchanged and run stays 1 until stall-result is written to 0. The results publish and run clears one cycle after that write.
- R8: Pointers A to D (addresses 4 to 7) and lengths A and B (addresses 8 and 9) read back the last host write at once. The datapath copies (`dp_ptr_*`, `dp_len_*`) change only at a start, and a register not written keeps its value.
- R9: Pointers keep 11 bits, lengths 9 bits and the shift amount 5 bits. Higher written bits are dropped and read as 0.
- R10: A complex operation ignores stall-result: done publishes the results and clears run in the next cycle. Function bits 11:0 stay writable while it runs.
- R11: `reg_rdata` shows the addressed register in the same cycle. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| boot_clr | input | 1 | Sequencer-ready pulse that clears the boot run state |
| dp_start | output | 1 | One-cycle start to the datapath |
| dp_basic_op | output | 12 | Latched basic operation bits |
| dp_seq_op | output | 3 | Latched complex operation select |
| dp_ptr_a | output | 11 | Active pointer A |
| dp_ptr_b | output | 11 | Active pointer B |
| dp_ptr_c | output | 11 | Active pointer C |
| dp_ptr_d | output | 11 | Active pointer D |
| dp_len_a | output | 9 | Active length A |
| dp_len_b | output | 9 | Active length B |
| dp_shift | output | 5 | Shift amount |
| dp_done | input | 1 | Completion pulse from the datapath |
| dp_cmp | input | 3 | Compare flags with done |
| dp_msw | input | 16 | Result most-significant-word info with done |
| dp_divmsw | input | 16 | Remainder most-significant-word info with done |
| irq | output | 1 | Interrupt, inverse of run |

## Verification
Reads are combinational and are sampled a little after the falling edge. Register writes, a start and a completion are each due one rising edge after the cycle that presents them. `dp_start` and the latched operation show up at the falling edge right after the write edge. Published results and the cleared run bit appear at the falling edge after the done edge. For a held result, the bench checks at the falling edge after the stall-clearing write that nothing has changed yet, then checks one cycle later that the results have published, which pins the extra cycle.

// File: rtl/bnc_pkg.sv
`timescale 1ns/1ps
package bnc_pkg;
  localparam int OPW  = 12;
  localparam int SELW = 3;
  localparam int CMPW = 3;
  localparam int RESW = 16;

  localparam int BIT_RUN   = 15;
  localparam int BIT_STALL = 24;
  localparam int SEL_LO    = 12;

  // operation bits that count toward the one-hot rule (bit 2 reserved, bit 3 modifier)
  localparam logic [OPW-1:0] OP_MASK    = 12'hFF3;
  // bits that are stored (bit 2 reserved)
  localparam logic [OPW-1:0] STORE_MASK = 12'hFFB;

  localparam int RA_FUNC   = 0;
  localparam int RA_SHIFT  = 1;
  localparam int RA_STATUS = 2;
  localparam int RA_PTR0   = 4;
  localparam int RA_LEN0   = 8;
  localparam int RA_CMP    = 12;
  localparam int RA_MSW    = 13;
  localparam int RA_DIVMSW = 14;

  typedef enum logic [2:0] {
    ST_BOOT  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_BASIC = 3'd2,
    ST_SEQ   = 3'd3,
    ST_HOLD  = 3'd4
  } state_e;

  typedef struct packed {
    logic [CMPW-1:0] cmp;
    logic [RESW-1:0] msw;
    logic [RESW-1:0] divmsw;
  } result_t;
endpackage

// File: rtl/bnc_opdec.sv
`timescale 1ns/1ps
module bnc_opdec
  import bnc_pkg::*;
(
  input  logic [OPW-1:0]  op_bits,
  input  logic [SELW-1:0] sel,
  output logic            legal,
  output logic            is_seq
);
  localparam int CW = $clog2(OPW + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < OPW; i++) begin
      if (OP_MASK[i] && op_bits[i]) ones = ones + CW'(1);
    end
  end

  assign is_seq = (sel != '0);
  assign legal  = is_seq ? (ones == '0) : (ones == CW'(1));
endmodule

// File: rtl/bnc_vecbank.sv
`timescale 1ns/1ps
module bnc_vecbank #(
  parameter int N = 4,
  parameter int W = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr,
  input  logic [W-1:0]        wdata,
  input  logic                load,
  output logic [N-1:0][W-1:0] shadow,
  output logic [N-1:0][W-1:0] active
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[g] <= '0;
      end else if (wr[g]) begin
        shadow[g] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active[g] <= '0;
      end else if (load) begin
        active[g] <= shadow[g];
      end
    end
  end

  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active));
endmodule

// File: rtl/bnc_fsm.sv
`timescale 1ns/1ps
module bnc_fsm
  import bnc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    boot_clr,
  input  logic    start_req,
  input  logic    start_legal,
  input  logic    start_seq,
  input  logic    stall,
  input  logic    done,
  input  result_t dp_res,
  output state_e  state,
  output logic    run,
  output logic    load,
  output logic    start_pulse,
  output logic    err,
  output result_t pub
);
  result_t pend;

  assign run  = (state != ST_IDLE);
  assign load = (state == ST_IDLE) && start_req && start_legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_BOOT;
      start_pulse <= 1'b0;
      err         <= 1'b0;
      pub         <= '0;
      pend        <= '0;
    end else begin
      start_pulse <= 1'b0;
      case (state)
        ST_BOOT: if (boot_clr) state <= ST_IDLE;
        ST_IDLE: begin
          if (start_req) begin
            if (start_legal) begin
              state       <= start_seq ? ST_SEQ : ST_BASIC;
              start_pulse <= 1'b1;
              err         <= 1'b0;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_BASIC: begin
          if (done) begin
            if (stall) begin
              pend  <= dp_res;
              state <= ST_HOLD;
            end else begin
              pub   <= dp_res;
              state <= ST_IDLE;
            end
          end
        end
        ST_SEQ: begin
          if (done) begin
            pub   <= dp_res;
            state <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (!stall) begin
            pub   <= pend;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(state) == ST_IDLE));

  // R3
  bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start_req && !start_legal) |=> (state == ST_IDLE && err));

  // R4
  done_pub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BASIC && done && !stall) |=> (state == ST_IDLE && pub == $past(dp_res)));

  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && stall) |=> (state == ST_HOLD && $stable(pub)));

  // R10
  seq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEQ && done) |=> (state == ST_IDLE));
endmodule

// File: rtl/bignum_ctl.sv
`timescale 1ns/1ps
module bignum_ctl
  import bnc_pkg::*;
#(
  parameter int DW   = 32,
  parameter int RAW  = 4,
  parameter int AW   = 11,
  parameter int LW   = 9,
  parameter int SHW  = 5,
  parameter int NPTR = 4,
  parameter int NLEN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RAW-1:0]  reg_addr,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            boot_clr,
  output logic            dp_start,
  output logic [11:0]     dp_basic_op,
  output logic [2:0]      dp_seq_op,
  output logic [AW-1:0]   dp_ptr_a,
  output logic [AW-1:0]   dp_ptr_b,
  output logic [AW-1:0]   dp_ptr_c,
  output logic [AW-1:0]   dp_ptr_d,
  output logic [LW-1:0]   dp_len_a,
  output logic [LW-1:0]   dp_len_b,
  output logic [SHW-1:0]  dp_shift,
  input  logic            dp_done,
  input  logic [2:0]      dp_cmp,
  input  logic [15:0]     dp_msw,
  input  logic [15:0]     dp_divmsw,
  output logic            irq
);
  state_e    state;
  logic      run, load, err;
  result_t   pub, dp_res;
  logic      wr_func, wr_shift, start_req, legal, is_seq, basic_lock;
  logic [NPTR-1:0]         ptr_wr;
  logic [NLEN-1:0]         len_wr;
  logic [NPTR-1:0][AW-1:0] ptr_sh, ptr_act;
  logic [NLEN-1:0][LW-1:0] len_sh, len_act;
  logic [OPW-1:0]          fn_op_q, op_act_q;
  logic [SELW-1:0]         fn_sel_q, sel_act_q;
  logic                    stall_q;
  logic [SHW-1:0]          shift_q;
  logic                    unused_wbits;

  assign unused_wbits = ^{reg_wdata[DW-1:BIT_STALL+1], reg_wdata[BIT_STALL-1:BIT_RUN+1]};

  assign wr_func    = reg_wr && (reg_addr == RAW'(RA_FUNC));
  assign wr_shift   = reg_wr && (reg_addr == RAW'(RA_SHIFT));
  assign start_req  = wr_func && reg_wdata[BIT_RUN];
  assign basic_lock = (state == ST_BASIC) || (state == ST_HOLD);

  for (genvar g = 0; g < NPTR; g++) begin : g_pwr
    assign ptr_wr[g] = reg_wr && (reg_addr == RAW'(RA_PTR0 + g));
  end
  for (genvar g = 0; g < NLEN; g++) begin : g_lwr
    assign len_wr[g] = reg_wr && (reg_addr == RAW'(RA_LEN0 + g));
  end

  bnc_opdec u_dec (
    .op_bits (reg_wdata[OPW-1:0]),
    .sel     (reg_wdata[SEL_LO+SELW-1:SEL_LO]),
    .legal   (legal),
    .is_seq  (is_seq)
  );

  bnc_vecbank #(.N(NPTR), .W(AW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr(ptr_wr), .wdata(reg_wdata[AW-1:0]),
    .load(load), .shadow(ptr_sh), .active(ptr_act)
  );

  bnc_vecbank #(.N(NLEN), .W(LW)) u_lens (
    .clk(clk), .rst_n(rst_n), .wr(len_wr), .wdata(reg_wdata[LW-1:0]),
    .load(load), .shadow(len_sh), .active(len_act)
  );

  assign dp_res.cmp    = dp_cmp;
  assign dp_res.msw    = dp_msw;
  assign dp_res.divmsw = dp_divmsw;

  bnc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .boot_clr(boot_clr),
    .start_req(start_req), .start_legal(legal), .start_seq(is_seq),
    .stall(stall_q), .done(dp_done), .dp_res(dp_res),
    .state(state), .run(run), .load(load), .start_pulse(dp_start),
    .err(err), .pub(pub)
  );

  // function word, shift amount and latched operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_op_q   <= '0;
      fn_sel_q  <= '0;
      stall_q   <= 1'b0;
      shift_q   <= '0;
      op_act_q  <= '0;
      sel_act_q <= '0;
    end else begin
      if (wr_func) begin
        if (!basic_lock) fn_op_q <= reg_wdata[OPW-1:0] & STORE_MASK;
        fn_sel_q <= reg_wdata[SEL_LO+SELW-1:SEL_LO];
        stall_q  <= reg_wdata[BIT_STALL];
      end
      if (wr_shift && !basic_lock) shift_q <= reg_wdata[SHW-1:0];
      if (load) begin
        op_act_q  <= reg_wdata[OPW-1:0] & STORE_MASK;
        sel_act_q <= reg_wdata[SEL_LO+SELW-1:SEL_LO];
      end
    end
  end

  assign dp_basic_op = op_act_q;
  assign dp_seq_op   = sel_act_q;
  assign dp_ptr_a    = ptr_act[0];
  assign dp_ptr_b    = ptr_act[1];
  assign dp_ptr_c    = ptr_act[2];
  assign dp_ptr_d    = ptr_act[3];
  assign dp_len_a    = len_act[0];
  assign dp_len_b    = len_act[1];
  assign dp_shift    = shift_q;
  assign irq         = ~run;

  // zero-wait read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RAW'(RA_FUNC)) begin
      reg_rdata[OPW-1:0]              = fn_op_q;
      reg_rdata[SEL_LO+SELW-1:SEL_LO] = fn_sel_q;
      reg_rdata[BIT_RUN]              = run;
      reg_rdata[BIT_STALL]            = stall_q;
    end
    if (reg_addr == RAW'(RA_SHIFT))  reg_rdata = DW'(shift_q);
    if (reg_addr == RAW'(RA_STATUS)) reg_rdata = DW'(err);
    for (int i = 0; i < NPTR; i++) begin
      if (reg_addr == RAW'(RA_PTR0 + i)) reg_rdata = DW'(ptr_sh[i]);
    end
    for (int i = 0; i < NLEN; i++) begin
      if (reg_addr == RAW'(RA_LEN0 + i)) reg_rdata = DW'(len_sh[i]);
    end
    if (reg_addr == RAW'(RA_CMP))    reg_rdata = DW'(pub.cmp);
    if (reg_addr == RAW'(RA_MSW))    reg_rdata = DW'(pub.msw);
    if (reg_addr == RAW'(RA_DIVMSW)) reg_rdata = DW'(pub.divmsw);
  end

  // R6
  shift_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (basic_lock && wr_shift) |=> $stable(shift_q));

  // R6
  func_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (basic_lock && wr_func) |=> $stable(fn_op_q));

  // R2
  op_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dp_start |-> (dp_basic_op == $past(reg_wdata[OPW-1:0] & STORE_MASK)));
endmodule

// File: tb/bignum_ctl_test.sv
`timescale 1ns/1ps
module bignum_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        boot_clr = 1'b0;
  logic        dp_start;
  logic [11:0] dp_basic_op;
  logic [2:0]  dp_seq_op;
  logic [10:0] dp_ptr_a, dp_ptr_b, dp_ptr_c, dp_ptr_d;
  logic [8:0]  dp_len_a, dp_len_b;
  logic [4:0]  dp_shift;
  logic        dp_done = 1'b0;
  logic [2:0]  dp_cmp = '0;
  logic [15:0] dp_msw = '0;
  logic [15:0] dp_divmsw = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bignum_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .boot_clr(boot_clr),
    .dp_start(dp_start), .dp_basic_op(dp_basic_op), .dp_seq_op(dp_seq_op),
    .dp_ptr_a(dp_ptr_a), .dp_ptr_b(dp_ptr_b), .dp_ptr_c(dp_ptr_c), .dp_ptr_d(dp_ptr_d),
    .dp_len_a(dp_len_a), .dp_len_b(dp_len_b), .dp_shift(dp_shift),
    .dp_done(dp_done), .dp_cmp(dp_cmp), .dp_msw(dp_msw), .dp_divmsw(dp_divmsw),
    .irq(irq)
  );

  localparam logic [3:0] A_FUNC = 4'd0, A_SHIFT = 4'd1, A_STAT = 4'd2, A_HOLE = 4'd3,
                         A_PA = 4'd4, A_PB = 4'd5, A_LA = 4'd8, A_LB = 4'd9,
                         A_CMP = 4'd12, A_MSW = 4'd13, A_DIV = 4'd14;

  // {legal, function word}
  localparam logic [32:0] VEC [0:8] = '{
    {1'b1, 32'h0000_8010},  // add
    {1'b1, 32'h0000_8001},  // multiply
    {1'b1, 32'h0000_8018},  // add with MS-one modifier
    {1'b0, 32'h0000_8030},  // add and subtract together
    {1'b1, 32'h0000_8800},  // copy
    {1'b0, 32'h0000_8000},  // nothing selected
    {1'b1, 32'h0000_5000 | 32'h8000},  // complex select 5
    {1'b0, 32'h0000_9010},  // complex plus basic
    {1'b0, 32'h0000_8401}   // multiply and compare
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic done(input logic [2:0] c, input logic [15:0] m, input logic [15:0] d);
    @(negedge clk);
    dp_done = 1'b1; dp_cmp = c; dp_msw = m; dp_divmsw = d;
    @(negedge clk);
    dp_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset / boot state
    rd(A_FUNC, v); chk("R1 run after reset", 32'(v[15]), 32'd1);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    rd(A_CMP, v);  chk("R1 cmp reset", v, 32'd0);
    rd(A_MSW, v);  chk("R1 msw reset", v, 32'd0);
    wr(A_FUNC, 32'h0000_8010);
    chk("R1 start ignored in boot", 32'(dp_start), 32'd0);
    rd(A_FUNC, v); chk("R1 run held in boot", 32'(v[15]), 32'd1);
    @(negedge clk); boot_clr = 1'b1;
    @(negedge clk); boot_clr = 1'b0;
    rd(A_FUNC, v); chk("R1 run cleared by boot_clr", 32'(v[15]), 32'd0);
    chk("R5 irq after boot", 32'(irq), 32'd1);

    // R9 widths, R11 unmapped
    wr(A_PA, 32'hFFFF_FFFF);    rd(A_PA, v);    chk("R9 ptr width", v, 32'h7FF);
    wr(A_LA, 32'hFFFF_FFFF);    rd(A_LA, v);    chk("R9 len width", v, 32'h1FF);
    wr(A_SHIFT, 32'hFFFF_FFFF); rd(A_SHIFT, v); chk("R9 shift width", v, 32'h1F);
    rd(A_HOLE, v); chk("R11 unmapped reads zero", v, 32'd0);
    chk("R8 active untouched before start", 32'(dp_ptr_a), 32'd0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 9; i++) begin
      logic [31:0] fn;
      logic [2:0]  ec;
      logic [15:0] em, ed;
      fn = VEC[i][31:0];
      ec = 3'(1 << (i % 3));
      em = 16'h0100 + 16'(i);
      ed = 16'h8000 | 16'(i);
      wr(A_FUNC, fn);
      if (VEC[i][32]) begin
        chk($sformatf("R2 start pulse vec%0d", i), 32'(dp_start), 32'd1);
        chk($sformatf("R2 basic op vec%0d", i), 32'(dp_basic_op), 32'(fn[11:0]));
        chk($sformatf("R2 select vec%0d", i), 32'(dp_seq_op), 32'(fn[14:12]));
        rd(A_STAT, v); chk($sformatf("R3 error clear vec%0d", i), v, 32'd0);
        chk($sformatf("R5 irq low vec%0d", i), 32'(irq), 32'd0);
        @(negedge clk);
        chk($sformatf("R2 pulse one cycle vec%0d", i), 32'(dp_start), 32'd0);
        done(ec, em, ed);
        rd(A_CMP, v); chk($sformatf("R4 cmp vec%0d", i), v, 32'(ec));
        rd(A_MSW, v); chk($sformatf("R4 msw vec%0d", i), v, 32'(em));
        rd(A_DIV, v); chk($sformatf("R4 divmsw vec%0d", i), v, 32'(ed));
        rd(A_FUNC, v); chk($sformatf("R4 run cleared vec%0d", i), 32'(v[15]), 32'd0);
        chk($sformatf("R5 irq high vec%0d", i), 32'(irq), 32'd1);
      end else begin
        chk($sformatf("R3 no start vec%0d", i), 32'(dp_start), 32'd0);
        rd(A_STAT, v); chk($sformatf("R3 error set vec%0d", i), v, 32'd1);
        rd(A_FUNC, v); chk($sformatf("R3 run stays 0 vec%0d", i), 32'(v[15]), 32'd0);
      end
    end

    // R6 lock and R8 double buffering
    wr(A_SHIFT, 32'd3);
    wr(A_PA, 32'h10);
    wr(A_LB, 32'd7);
    wr(A_FUNC, 32'h0000_8010);
    chk("R8 ptr loaded at start", 32'(dp_ptr_a), 32'h10);
    wr(A_SHIFT, 32'd9);
    rd(A_SHIFT, v); chk("R6 shift write ignored", v, 32'd3);
    chk("R6 dp_shift steady", 32'(dp_shift), 32'd3);
    wr(A_FUNC, 32'h0000_0001);
    rd(A_FUNC, v); chk("R6 op bits locked", 32'(v[11:0]), 32'h010);
    wr(A_FUNC, 32'h0000_8001);
    chk("R6 no restart", 32'(dp_start), 32'd0);
    wr(A_PA, 32'h20);
    wr(A_LB, 32'd5);
    rd(A_PA, v); chk("R8 shadow readback", v, 32'h20);
    chk("R8 active ptr kept", 32'(dp_ptr_a), 32'h10);
    chk("R8 active len kept", 32'(dp_len_b), 32'd7);
    done(3'd1, 16'h0005, 16'h0006);
    wr(A_FUNC, 32'h0000_8020);
    chk("R8 new ptr on next start", 32'(dp_ptr_a), 32'h20);
    chk("R8 new len on next start", 32'(dp_len_b), 32'd5);
    chk("R8 unwritten len kept", 32'(dp_len_a), 32'h1FF);
    done(3'd2, 16'h0007, 16'h0008);

    // R7 stall-result
    wr(A_FUNC, 32'h0100_8010);
    done(3'd4, 16'h0333, 16'h0444);
    rd(A_FUNC, v); chk("R7 run held", 32'(v[15]), 32'd1);
    rd(A_MSW, v);  chk("R7 msw held", v, 32'h0007);
    repeat (3) @(negedge clk);
    rd(A_CMP, v);  chk("R7 cmp still held", v, 32'd2);
    chk("R5 irq low while held", 32'(irq), 32'd0);
    wr(A_FUNC, 32'h0000_0010);
    rd(A_FUNC, v); chk("R7 run one more cycle", 32'(v[15]), 32'd1);
    rd(A_MSW, v);  chk("R7 msw not yet", v, 32'h0007);
    @(negedge clk);
    rd(A_FUNC, v); chk("R7 run cleared after stall off", 32'(v[15]), 32'd0);
    rd(A_MSW, v);  chk("R7 msw published", v, 32'h0333);
    rd(A_DIV, v);  chk("R7 divmsw published", v, 32'h0444);

    // R10 complex op ignores stall, op bits writable
    wr(A_FUNC, 32'h0100_D000);
    chk("R10 complex start", 32'(dp_start), 32'd1);
    wr(A_FUNC, 32'h0100_5002);
    rd(A_FUNC, v); chk("R10 op bits writable", 32'(v[11:0]), 32'h002);
    done(3'd1, 16'h0055, 16'h0066);
    rd(A_FUNC, v); chk("R10 run cleared despite stall", 32'(v[15]), 32'd0);
    rd(A_MSW, v);  chk("R10 msw published", v, 32'h0055);
    chk("R5 irq after complex", 32'(irq), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule